// File: doc/BRIEF.md
# Dual Decade Counter with Separate Prescaler Stages

This block holds two 4-bit counters that work fully apart from each other. Each counter is made of a single-bit divide-by-two stage and a three-bit divide-by-five stage, and each stage has its own count input. A stage advances on a high-to-low transition of its count input. Every count input is brought into the one system clock domain through a two-flop synchronizer, and its falling edge is found from the registered samples, so the ripple behaviour of a discrete counter becomes a plain synchronous design.

The two stages can be chained inside the counter with a per-counter wiring select. The first chain feeds the divide-by-two output into the divide-by-five stage and gives a BCD count. The second chain feeds the divide-by-five MSB into the divide-by-two stage and gives a bi-quinary count. A chained stage sees its feeding output as an internal edge. Outside the block, the top output of one counter can be wired to the count input of the other to divide by up to 100. Each counter has an active-high clear. The clear takes effect at once and is released in step with the system clock.

Top module: `dual_decade_counter`

## Requirements
- R1: In separate wiring, each falling edge of a counter's A input toggles its QA output three system clock edges after the input falls. A rising edge of A changes nothing.
- R2: In separate wiring, each falling edge of the B input steps {QD,QC,QB} (QD most significant) through 0,1,2,3,4 and then back to 0. The value never leaves the range 0..4, and it changes only on an advance.
- R3: While a counter's clear input is high, its four outputs are low and it does not count. The outputs go low without waiting for a clock edge.
- R4: Clear is released on the second system clock edge after the input falls. An edge that is detected in the first cycle after release is ignored. Later edges count normally.
- R5: Wiring code 1 selects BCD. A falling QA drives the divide-by-five stage one clock later, so {QD,QC,QB,QA} counts 0 to 9 and wraps to 0. The B input is ignored.
- R6: Wiring code 2 selects bi-quinary. A falling QD drives the divide-by-two stage one clock later, and QA becomes the top digit. The A input is ignored.
- R7: Wiring codes 0 and 3 both select separate stages. The two counters share nothing: the inputs, clear and wiring of one never change the other's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_i | input | NUM_CTR | Per-counter clear, active high |
| wiring_i | input | 2*NUM_CTR | Per-counter stage wiring code, counter k in bits [2k+1:2k] |
| cnt_a_i | input | NUM_CTR | Per-counter count input of the divide-by-two stage |
| cnt_b_i | input | NUM_CTR | Per-counter count input of the divide-by-five stage |
| qa_o | output | NUM_CTR | Divide-by-two output |
| qb_o | output | NUM_CTR | Divide-by-five output, bit 0 |
| qc_o | output | NUM_CTR | Divide-by-five output, bit 1 |
| qd_o | output | NUM_CTR | Divide-by-five output, bit 2 (MSB) |

## Verification
Some rules hold in every cycle, and the assertions check those. Each advance toggles QA or steps the five-state value. Without an advance the outputs hold still. The five-state value stays within 0..4. Clear leaves the outputs at zero. Nothing counts in the first cycle after release. Other behaviour can only be shown by the bench's scenarios. These are the exact three-clock latency from a pin, the full BCD and bi-quinary sequences with their wraps, the ignored inputs in each wiring, the edge lost at release, and the independence of the two counters under random pulses.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [1:0] {
    WIRE_SPLIT  = 2'd0,
    WIRE_BCD    = 2'd1,
    WIRE_BIQ    = 2'd2,
    WIRE_SPLIT2 = 2'd3
  } wiring_e;

  localparam int QUIN_W   = 3;
  localparam int QUIN_TOP = 4;

  // Next state of the five-state stage; codes above the top return to zero.
  function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] cur);
    if (cur >= QUIN_W'(QUIN_TOP)) return '0;
    return cur + QUIN_W'(1);
  endfunction

endpackage

// File: rtl/ddc_fall_detect.sv
module ddc_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] shr;

  always_ff @(posedge clk) begin
    shr <= {shr[STAGES-1:0], din};
  end

  logic synced, history;
  assign synced  = shr[STAGES-1];
  assign history = shr[STAGES];
  assign fall    = history & ~synced;

endmodule

// File: rtl/ddc_reset_sync.sv
module ddc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  output logic rst_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) chain <= '1;
    else     chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain[STAGES-1];

endmodule

// File: rtl/ddc_counter.sv
module ddc_counter
  import ddc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       clr,
  input  logic [1:0] wiring,
  input  logic       a_in,
  input  logic       b_in,
  output logic       qa,
  output logic       qb,
  output logic       qc,
  output logic       qd
);
  wiring_e mode;
  assign mode = wiring_e'(wiring);

  // Synchronized clear, async assert / sync release
  logic ctr_rst;
  ddc_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .clr(clr), .rst_out(ctr_rst)
  );

  // Falling edges of the pins
  logic pin_fall_a, pin_fall_b;
  ddc_fall_detect #(.STAGES(SYNC_STAGES)) u_edge_a (
    .clk(clk), .din(a_in), .fall(pin_fall_a)
  );
  ddc_fall_detect #(.STAGES(SYNC_STAGES)) u_edge_b (
    .clk(clk), .din(b_in), .fall(pin_fall_b)
  );

  // State
  logic              two_q;
  logic [QUIN_W-1:0] quin_q;
  logic              two_hist, msb_hist;
  logic              armed;

  // Internal cascade edges, one clock after the feeding output falls
  logic two_fall, msb_fall;
  assign two_fall = two_hist & ~two_q;
  assign msb_fall = msb_hist & ~quin_q[QUIN_W-1];

  // Advance events, brought out for the assertions
  logic adv_two, adv_quin;
  assign adv_two  = armed & ((mode == WIRE_BIQ) ? msb_fall : pin_fall_a);
  assign adv_quin = armed & ((mode == WIRE_BCD) ? two_fall : pin_fall_b);

  always_ff @(posedge clk or posedge ctr_rst) begin
    if (ctr_rst) begin
      two_q    <= 1'b0;
      quin_q   <= '0;
      two_hist <= 1'b0;
      msb_hist <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed    <= 1'b1;
      two_hist <= two_q;
      msb_hist <= quin_q[QUIN_W-1];
      if (adv_two)  two_q  <= ~two_q;
      if (adv_quin) quin_q <= quin_next(quin_q);
    end
  end

  assign qa = two_q;
  assign qb = quin_q[0];
  assign qc = quin_q[1];
  assign qd = quin_q[2];

  // ---------------- assertions ----------------
  assert_two_toggle_R1: assert property (@(posedge clk) disable iff (ctr_rst)
    adv_two |=> (two_q != $past(two_q)));

  assert_two_hold_R1: assert property (@(posedge clk) disable iff (ctr_rst)
    !adv_two |=> $stable(two_q));

  assert_quin_range_R2: assert property (@(posedge clk) disable iff (ctr_rst)
    quin_q <= QUIN_W'(QUIN_TOP));

  assert_quin_wrap_R2: assert property (@(posedge clk) disable iff (ctr_rst)
    (adv_quin && quin_q == QUIN_W'(QUIN_TOP)) |=> (quin_q == '0));

  assert_quin_hold_R2: assert property (@(posedge clk) disable iff (ctr_rst)
    !adv_quin |=> $stable(quin_q));

  assert_clear_zero_R3: assert property (@(posedge clk)
    ctr_rst |=> (two_q == 1'b0 && quin_q == '0));

  assert_release_quiet_R4: assert property (@(posedge clk) disable iff (ctr_rst)
    !armed |=> ($stable(two_q) && $stable(quin_q)));

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter #(
  parameter int NUM_CTR     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic [NUM_CTR-1:0]   clr_i,
  input  logic [2*NUM_CTR-1:0] wiring_i,
  input  logic [NUM_CTR-1:0]   cnt_a_i,
  input  logic [NUM_CTR-1:0]   cnt_b_i,
  output logic [NUM_CTR-1:0]   qa_o,
  output logic [NUM_CTR-1:0]   qb_o,
  output logic [NUM_CTR-1:0]   qc_o,
  output logic [NUM_CTR-1:0]   qd_o
);
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    ddc_counter #(
      .SYNC_STAGES(SYNC_STAGES),
      .RST_STAGES (RST_STAGES)
    ) u_ctr (
      .clk   (clk),
      .clr   (clr_i[k]),
      .wiring(wiring_i[2*k +: 2]),
      .a_in  (cnt_a_i[k]),
      .b_in  (cnt_b_i[k]),
      .qa    (qa_o[k]),
      .qb    (qb_o[k]),
      .qc    (qc_o[k]),
      .qd    (qd_o[k])
    );
  end

endmodule

// File: tb/tb_dual_decade_counter.sv
`timescale 1ns/1ps
module tb_dual_decade_counter;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic [N-1:0] clr_i = '0;
  logic [2*N-1:0] wiring_i = '0;
  logic [N-1:0] cnt_a_i = '0;
  logic [N-1:0] cnt_b_i = '0;
  logic [N-1:0] qa_o, qb_o, qc_o, qd_o;

  dual_decade_counter dut (
    .clk(clk), .clr_i(clr_i), .wiring_i(wiring_i),
    .cnt_a_i(cnt_a_i), .cnt_b_i(cnt_b_i),
    .qa_o(qa_o), .qb_o(qb_o), .qc_o(qc_o), .qd_o(qd_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ref_two [N];
  int ref_five[N];

  // Five-state step, written as a modulo
  function automatic int five_step(int v);
    return (v + 1) % 5;
  endfunction

  function automatic int observed(int k);
    return {qd_o[k], qc_o[k], qb_o[k], qa_o[k]};
  endfunction

  function automatic int expected(int k);
    return ref_five[k] * 2 + ref_two[k];
  endfunction

  task automatic check_all(string tag);
    for (int k = 0; k < N; k++) begin
      checks++;
      if (observed(k) != expected(k)) begin
        errors++;
        $display("FAIL %s counter %0d: got %0d expected %0d", tag, k, observed(k), expected(k));
      end
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One pulse on input A (which=0) or B (which=1) of counter k
  task automatic pulse(int k, int which, string tag);
    int m, old;
    m = wiring_i[2*k +: 2];
    if (which == 0) cnt_a_i[k] = 1'b1; else cnt_b_i[k] = 1'b1;
    wait_clk(4);
    check_all("R1 rising edge has no effect");
    if (which == 0) cnt_a_i[k] = 1'b0; else cnt_b_i[k] = 1'b0;
    if (which == 0) begin
      if (m != 2) begin
        old = ref_two[k];
        ref_two[k] ^= 1;
        if (m == 1 && old == 1) ref_five[k] = five_step(ref_five[k]);
      end
    end else begin
      if (m != 1) begin
        old = ref_five[k];
        ref_five[k] = five_step(ref_five[k]);
        if (m == 2 && old == 4) ref_two[k] ^= 1;
      end
    end
    wait_clk(6);
    check_all(tag);
  endtask

  task automatic clear_ctr(int k);
    clr_i[k] = 1'b1;
    ref_two[k] = 0;
    ref_five[k] = 0;
    #1;
    check_all("R3 immediate clear");
    wait_clk(3);
    check_all("R3 clear held");
    clr_i[k] = 1'b0;
    wait_clk(5);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin ref_two[k] = 0; ref_five[k] = 0; end
    #1 clr_i = '1;
    wait_clk(4);
    check_all("R3 reset state");
    clr_i = '0;
    wait_clk(5);
    check_all("R3 after release");

    // R1 and R2: separate stages on counter 0
    pulse(0, 0, "R1 toggle");
    pulse(0, 0, "R1 toggle back");
    // R1 latency: output must still be old on the second edge, new on the third
    cnt_a_i[0] = 1'b1; wait_clk(4);
    cnt_a_i[0] = 1'b0; wait_clk(2);
    check_all("R1 not yet changed after two edges");
    ref_two[0] = 1; wait_clk(1);
    check_all("R1 changed after third edge");
    for (int i = 0; i < 6; i++) pulse(0, 1, "R2 five-state step and wrap");

    // R5: BCD on counter 0
    clear_ctr(0);
    wiring_i[1:0] = 2'd1;
    for (int i = 0; i < 11; i++) pulse(0, 0, "R5 BCD count");
    pulse(0, 1, "R5 B input ignored");

    // R6: bi-quinary on counter 1
    wiring_i[3:2] = 2'd2;
    for (int i = 0; i < 11; i++) pulse(1, 1, "R6 bi-quinary count");
    pulse(1, 0, "R6 A input ignored");

    // R7: wiring code 3 behaves as separate stages
    clear_ctr(1);
    wiring_i[3:2] = 2'd3;
    for (int i = 0; i < 5; i++) pulse(1, 1, "R7 code 3 separate B");
    pulse(1, 0, "R7 code 3 separate A");

    // R4: edge falling at release is lost, the next one counts
    wiring_i[1:0] = 2'd0;
    clr_i[0] = 1'b1; ref_two[0] = 0; ref_five[0] = 0;
    cnt_a_i[0] = 1'b1;
    wait_clk(4);
    clr_i[0] = 1'b0; cnt_a_i[0] = 1'b0;
    wait_clk(8);
    check_all("R4 edge at release ignored");
    pulse(0, 0, "R4 counting resumes");

    // R3 mid-count clear; counter 1 must be untouched (R7)
    pulse(0, 1, "R3 setup");
    pulse(0, 1, "R3 setup");
    clear_ctr(0);
    check_all("R7 other counter unaffected by clear");

    // Random mix, fixed seed
    void'($urandom(32'h5eed_0390));
    for (int i = 0; i < 60; i++) begin
      int k, w;
      k = $urandom_range(0, N - 1);
      w = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) begin
        wiring_i[2*k +: 2] = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 19) == 0) clear_ctr(k);
      pulse(k, w, "R7 random independent pulses");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule